// File: doc/BRIEF.md
# Region-Based Bus Access Permission Checker

This block decides, for every bus access, whether the requesting master may proceed. Software programs a set of address windows, each with an inclusive lower and upper bound, a permission word and an enable bit. Each master carries a 2-bit security mode with its request. Mode 0 is the trusted mode and always passes. Modes 1, 2 and 3 are untrusted. An untrusted access passes only if some enabled window covers the address and that window grants the needed read, write or execute right to the master's mode.

The block serves several independent access paths. Each path has its own request port and its own filter enable. Each path also has a sticky violation flag. The first refused access on a path records the master id, the mode, the map of windows that covered the address, and the address itself. These details stay frozen until software clears the flag. The flag drives a per-path interrupt through an enable mask. Configuration and readback go through a simple single-cycle register port.

Top module: `bus_perm_guard`

## Requirements
- R1: A request with mode 0 (trusted) is granted whatever the windows hold. Modes 1, 2 and 3 are untrusted.
- R2: A window covers an address when lower <= address <= upper, with both bounds included. A window whose bit in the window-enable register (offset 0x004, bit r for window r) is clear never covers anything.
- R3: A window's attribute word holds a 4-bit slot for each untrusted mode m, at bit 4*(m-1). Slot bit 0 is read, bit 1 is write and bit 2 is execute; req_kind encodes 0 read, 1 write, 2 execute. An untrusted request is granted if any covering window has the needed bit set for its mode. It is refused if no window covers it, and a req_kind of 3 is always refused.
- R4: Only bits 2:0 of each attribute slot are stored. The attribute word always reads back as the written value ANDed with 0x777.
- R5: A path whose bit in the path-enable register (offset 0x000) is clear grants every request and never raises its violation flag.
- R6: resp_valid and resp_grant for a path change on the first clock edge after the request is presented. resp_valid is high for exactly the cycles after a cycle with req_valid high.
- R7: A refused request on an enabled path sets that path's violation flag (status register bit 0). The details are captured only when the flag is clear; later refusals leave them unchanged.
- R8: Info word 0 holds the master id in bits 22:18, the mode in bits 17:16 and the covering-window map in bits 15:0. Info word 1 holds the refused address.
- R9: Writing a value with bit 0 set to a path's clear register clears its flag. Writing with bit 0 clear has no effect. If a refusal arrives in the same cycle as the clear, the flag stays set and the new details are captured.
- R10: irq[p] is high exactly when path p's flag is set and bit p of the interrupt-enable register (offset 0x008) is set.
- R11: After reset, all flags, enables, responses and interrupts are zero.
- R12: Window r sits at 0x100 + 0xC*r: lower bound at +0, upper bound at +4, attribute at +8. Path p sits at 0x200 + 0x10*p: status at +0, clear at +4, info word 0 at +8, info word 1 at +0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| req_valid | input | NUM_PATHS | Request present, one bit per path |
| req_addr | input | NUM_PATHS*ADDR_W | Request address per path |
| req_mid | input | NUM_PATHS*MID_W | Master id per path |
| req_mode | input | NUM_PATHS*2 | Security mode per path |
| req_kind | input | NUM_PATHS*2 | Access kind per path (0 read, 1 write, 2 execute) |
| resp_valid | output | NUM_PATHS | Registered response strobe |
| resp_grant | output | NUM_PATHS | Registered grant (1) or refusal (0) |
| irq | output | NUM_PATHS | Per-path violation interrupt |

## Verification
The bench probes each window bound exactly at the bound and one address outside it. A design with exclusive or off-by-one comparisons would refuse the edge address or grant the outside one. Overlapping windows with different rights check that grants combine by OR. A design that used only the first covering window would refuse an access that the second window permits, and the captured window map would show one bit instead of two. A second refusal while the flag is set must leave the details unchanged, so a design that overwrites them would report the newer master id. A clear write that meets a refusal in the same cycle must leave the flag set, so a design where clear wins would lose the violation. A disabled window, a disabled path, a reserved access kind and the masked attribute readback close the remaining gaps.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    localparam int CFG_AW        = 12;
    localparam int OFS_PATH_EN   = 'h000;
    localparam int OFS_REGION_EN = 'h004;
    localparam int OFS_IRQ_EN    = 'h008;
    localparam int REGION_BASE   = 'h100;
    localparam int REGION_STRIDE = 'hC;
    localparam int PATH_BASE     = 'h200;
    localparam int PATH_STRIDE   = 'h10;
    localparam int ATTR_W        = 12;
    localparam logic [ATTR_W-1:0] ATTR_KEEP = 12'h777;

    typedef enum logic [1:0] {
        MODE_TRUSTED = 2'd0,
        MODE_UNTR1   = 2'd1,
        MODE_UNTR2   = 2'd2,
        MODE_UNTR3   = 2'd3
    } sec_mode_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/bpg_region_bank.sv
module bpg_region_bank
    import bpg_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [CFG_AW-1:0]                      wr_addr,
    input  logic [31:0]                            wr_data,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     lo_o,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     hi_o,
    output logic [NUM_REGIONS-1:0][ATTR_W-1:0]     attr_o,
    output logic [NUM_REGIONS-1:0]                 en_o
);
    typedef struct packed {
        logic [NUM_REGIONS-1:0][ADDR_W-1:0] lo;
        logic [NUM_REGIONS-1:0][ADDR_W-1:0] hi;
        logic [NUM_REGIONS-1:0][ATTR_W-1:0] attr;
        logic [NUM_REGIONS-1:0]             en;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            if (wr_addr == CFG_AW'(OFS_REGION_EN))
                bank_d.en = wr_data[NUM_REGIONS-1:0];
            for (int r = 0; r < NUM_REGIONS; r++) begin
                if (wr_addr == CFG_AW'(REGION_BASE + r * REGION_STRIDE))
                    bank_d.lo[r] = wr_data[ADDR_W-1:0];
                if (wr_addr == CFG_AW'(REGION_BASE + r * REGION_STRIDE + 4))
                    bank_d.hi[r] = wr_data[ADDR_W-1:0];
                if (wr_addr == CFG_AW'(REGION_BASE + r * REGION_STRIDE + 8))
                    bank_d.attr[r] = wr_data[ATTR_W-1:0] & ATTR_KEEP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign lo_o   = bank_q.lo;
    assign hi_o   = bank_q.hi;
    assign attr_o = bank_q.attr;
    assign en_o   = bank_q.en;

    AST_ATTR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bank_q.attr[0] & ~ATTR_KEEP) == '0)) else $error("attr reserved bits set"); // R4
endmodule

// File: rtl/bpg_path_check.sv
module bpg_path_check
    import bpg_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32
) (
    input  logic                               path_en,
    input  logic                               valid,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [1:0]                         mode,
    input  logic [1:0]                         kind,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] lo,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] hi,
    input  logic [NUM_REGIONS-1:0][ATTR_W-1:0] attr,
    input  logic [NUM_REGIONS-1:0]             region_en,
    output logic [NUM_REGIONS-1:0]             hit_o,
    output logic                               grant_o,
    output logic                               viol_o
);
    logic [NUM_REGIONS-1:0] permit;
    logic [3:0]             slot_idx;
    logic                   trusted;

    assign trusted  = (mode == MODE_TRUSTED);
    assign slot_idx = {2'(mode - 2'd1), kind};

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
        logic [15:0] attr_wide;
        assign attr_wide = {{(16 - ATTR_W){1'b0}}, attr[r]};
        assign hit_o[r]  = region_en[r] && (addr >= lo[r]) && (addr <= hi[r]);
        assign permit[r] = hit_o[r] && !trusted && attr_wide[slot_idx];
    end

    assign grant_o = !path_en || trusted || (|permit);
    assign viol_o  = valid && !grant_o;
endmodule

// File: rtl/bpg_path_excp.sv
module bpg_path_excp
    import bpg_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32,
    parameter int MID_W       = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   viol,
    input  logic                   clr,
    input  logic [MID_W-1:0]       mid,
    input  logic [1:0]             mode,
    input  logic [NUM_REGIONS-1:0] hit,
    input  logic [ADDR_W-1:0]      addr,
    output logic                   status_o,
    output logic [31:0]            info0_o,
    output logic [ADDR_W-1:0]      info1_o
);
    localparam int MID_LSB  = 18;
    localparam int MODE_LSB = 16;

    typedef struct packed {
        logic              status;
        logic [31:0]       info0;
        logic [ADDR_W-1:0] info1;
    } excp_t;

    excp_t ex_d, ex_q;
    logic [31:0] packed_info;

    always_comb begin
        packed_info = '0;
        packed_info[NUM_REGIONS-1:0]      = hit;
        packed_info[MODE_LSB +: 2]        = mode;
        packed_info[MID_LSB +: MID_W]     = mid;
    end

    always_comb begin
        ex_d = ex_q;
        if (clr) ex_d.status = 1'b0;
        if (viol && (!ex_q.status || clr)) begin
            ex_d.status = 1'b1;
            ex_d.info0  = packed_info;
            ex_d.info1  = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ex_q <= '0;
        else        ex_q <= ex_d;
    end

    assign status_o = ex_q.status;
    assign info0_o  = ex_q.info0;
    assign info1_o  = ex_q.info1;

    AST_SET_ON_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> ex_q.status) else $error("violation not flagged"); // R9
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_q.status && !clr) |=> ex_q.status) else $error("flag dropped"); // R7
    AST_INFO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_q.status && !clr) |=> ($stable(ex_q.info0) && $stable(ex_q.info1))) else $error("info overwritten"); // R7
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !viol) |=> !ex_q.status) else $error("clear ignored"); // R9
endmodule

// File: rtl/bus_perm_guard.sv
module bus_perm_guard
    import bpg_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int NUM_PATHS   = 4,
    parameter int ADDR_W      = 32,
    parameter int MID_W       = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [11:0]                   cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    output logic [31:0]                   cfg_rdata,
    input  logic [NUM_PATHS-1:0]          req_valid,
    input  logic [NUM_PATHS*ADDR_W-1:0]   req_addr,
    input  logic [NUM_PATHS*MID_W-1:0]    req_mid,
    input  logic [NUM_PATHS*2-1:0]        req_mode,
    input  logic [NUM_PATHS*2-1:0]        req_kind,
    output logic [NUM_PATHS-1:0]          resp_valid,
    output logic [NUM_PATHS-1:0]          resp_grant,
    output logic [NUM_PATHS-1:0]          irq
);
    typedef struct packed {
        logic [NUM_PATHS-1:0] path_en;
        logic [NUM_PATHS-1:0] irq_en;
        logic [NUM_PATHS-1:0] rvalid;
        logic [NUM_PATHS-1:0] rgrant;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NUM_REGIONS-1:0][ADDR_W-1:0] win_lo, win_hi;
    logic [NUM_REGIONS-1:0][ATTR_W-1:0] win_attr;
    logic [NUM_REGIONS-1:0]             win_en;

    logic [NUM_PATHS-1:0]                  grant_w, viol_w, clr_w, status_w;
    logic [NUM_PATHS-1:0][NUM_REGIONS-1:0] hit_w;
    logic [NUM_PATHS-1:0][31:0]            info0_w;
    logic [NUM_PATHS-1:0][ADDR_W-1:0]      info1_w;

    bpg_region_bank #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .lo_o    (win_lo),
        .hi_o    (win_hi),
        .attr_o  (win_attr),
        .en_o    (win_en)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        assign clr_w[p] = cfg_we && cfg_wdata[0] &&
                          (cfg_addr == CFG_AW'(PATH_BASE + p * PATH_STRIDE + 4));

        bpg_path_check #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_chk (
            .path_en   (st_q.path_en[p]),
            .valid     (req_valid[p]),
            .addr      (req_addr[p*ADDR_W +: ADDR_W]),
            .mode      (req_mode[2*p +: 2]),
            .kind      (req_kind[2*p +: 2]),
            .lo        (win_lo),
            .hi        (win_hi),
            .attr      (win_attr),
            .region_en (win_en),
            .hit_o     (hit_w[p]),
            .grant_o   (grant_w[p]),
            .viol_o    (viol_w[p])
        );

        bpg_path_excp #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .MID_W(MID_W)) u_excp (
            .clk      (clk),
            .rst_n    (rst_n),
            .viol     (viol_w[p]),
            .clr      (clr_w[p]),
            .mid      (req_mid[p*MID_W +: MID_W]),
            .mode     (req_mode[2*p +: 2]),
            .hit      (hit_w[p]),
            .addr     (req_addr[p*ADDR_W +: ADDR_W]),
            .status_o (status_w[p]),
            .info0_o  (info0_w[p]),
            .info1_o  (info1_w[p])
        );

        AST_TRUSTED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_mode[2*p +: 2] == 2'd0) |=> resp_grant[p]) else $error("trusted refused"); // R1
        AST_OFF_PATH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && !st_q.path_en[p]) |=> resp_grant[p]) else $error("disabled path refused"); // R5
        AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[p] |=> resp_valid[p]) else $error("response missing"); // R6
        AST_RESP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[p] |=> !resp_valid[p]) else $error("spurious response"); // R6
    end

    always_comb begin
        st_d = st_q;
        if (cfg_we && cfg_addr == CFG_AW'(OFS_PATH_EN)) st_d.path_en = cfg_wdata[NUM_PATHS-1:0];
        if (cfg_we && cfg_addr == CFG_AW'(OFS_IRQ_EN))  st_d.irq_en  = cfg_wdata[NUM_PATHS-1:0];
        st_d.rvalid = req_valid;
        st_d.rgrant = req_valid & grant_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CFG_AW'(OFS_PATH_EN))   cfg_rdata[NUM_PATHS-1:0]   = st_q.path_en;
        if (cfg_addr == CFG_AW'(OFS_IRQ_EN))    cfg_rdata[NUM_PATHS-1:0]   = st_q.irq_en;
        if (cfg_addr == CFG_AW'(OFS_REGION_EN)) cfg_rdata[NUM_REGIONS-1:0] = win_en;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (cfg_addr == CFG_AW'(REGION_BASE + r * REGION_STRIDE))
                cfg_rdata[ADDR_W-1:0] = win_lo[r];
            if (cfg_addr == CFG_AW'(REGION_BASE + r * REGION_STRIDE + 4))
                cfg_rdata[ADDR_W-1:0] = win_hi[r];
            if (cfg_addr == CFG_AW'(REGION_BASE + r * REGION_STRIDE + 8))
                cfg_rdata[ATTR_W-1:0] = win_attr[r];
        end
        for (int p = 0; p < NUM_PATHS; p++) begin
            if (cfg_addr == CFG_AW'(PATH_BASE + p * PATH_STRIDE))
                cfg_rdata[0] = status_w[p];
            if (cfg_addr == CFG_AW'(PATH_BASE + p * PATH_STRIDE + 8))
                cfg_rdata = info0_w[p];
            if (cfg_addr == CFG_AW'(PATH_BASE + p * PATH_STRIDE + 12))
                cfg_rdata[ADDR_W-1:0] = info1_w[p];
        end
    end

    assign resp_valid = st_q.rvalid;
    assign resp_grant = st_q.rgrant;
    assign irq        = status_w & st_q.irq_en;
endmodule

// File: tb/sim_bus_perm_guard.sv
`timescale 1ns/1ps
module sim_bus_perm_guard;
    localparam int P  = 4;
    localparam int AW = 32;
    localparam int MW = 5;
    localparam int NV = 13;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [11:0]     cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [31:0]     cfg_rdata;
    logic [P-1:0]    req_valid = '0;
    logic [P*AW-1:0] req_addr = '0;
    logic [P*MW-1:0] req_mid = '0;
    logic [P*2-1:0]  req_mode = '0;
    logic [P*2-1:0]  req_kind = '0;
    logic [P-1:0]    resp_valid, resp_grant, irq;

    int checks = 0;
    int failures = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    bus_perm_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_mid(req_mid), .req_mode(req_mode),
        .req_kind(req_kind), .resp_valid(resp_valid), .resp_grant(resp_grant), .irq(irq)
    );

    // {address, mode, kind, expected grant}
    localparam logic [36:0] VEC [NV] = '{
        {32'h0000_1000, 2'd1, 2'd0, 1'b1},  // R2 lower bound inclusive
        {32'h0000_1FFF, 2'd1, 2'd1, 1'b1},  // R2 upper bound inclusive
        {32'h0000_0FFF, 2'd1, 2'd0, 1'b0},  // R2 below window
        {32'h0000_2000, 2'd1, 2'd1, 1'b0},  // R3 write not allowed
        {32'h0000_2000, 2'd1, 2'd2, 1'b1},  // R3 execute allowed
        {32'h0000_1800, 2'd2, 2'd1, 1'b0},  // R3 mode 2 write refused
        {32'h0000_1800, 2'd3, 2'd2, 1'b1},  // R3 overlap OR
        {32'h0000_1500, 2'd3, 2'd0, 1'b0},  // R3 mode 3 no right
        {32'h0000_3000, 2'd2, 2'd1, 1'b0},  // R2 disabled window
        {32'h0000_9000, 2'd0, 2'd1, 1'b1},  // R1 trusted
        {32'h0000_40FF, 2'd2, 2'd2, 1'b1},  // R3 slot offset mode 2
        {32'h0000_4100, 2'd2, 2'd0, 1'b0},  // R3 no cover
        {32'h0000_4000, 2'd1, 2'd3, 1'b0}   // R3 reserved kind
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rdreg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic drive(input int p, input logic [31:0] a, input logic [4:0] m,
                         input logic [1:0] mode, input logic [1:0] kind);
        req_valid[p] = 1'b1;
        req_addr[p*AW +: AW] = a;
        req_mid[p*MW +: MW] = m;
        req_mode[2*p +: 2] = mode;
        req_kind[2*p +: 2] = kind;
    endtask

    task automatic issue(input int p, input logic [31:0] a, input logic [4:0] m,
                         input logic [1:0] mode, input logic [1:0] kind);
        @(negedge clk);
        drive(p, a, m, mode, kind);
        @(negedge clk);
        req_valid = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        #1;
        chk(32'(resp_valid), 0, "R11 resp_valid");
        chk(32'(irq), 0, "R11 irq");
        rdreg(12'h200, rd); chk(rd, 0, "R11 status");
        rdreg(12'h000, rd); chk(rd, 0, "R11 path enable");

        // configuration (R12 map)
        wr(12'h000, 32'h3);
        wr(12'h100, 32'h1000); wr(12'h104, 32'h1FFF); wr(12'h108, 32'h013);
        wr(12'h10C, 32'h1800); wr(12'h110, 32'h27FF); wr(12'h114, 32'h704);
        wr(12'h118, 32'h3000); wr(12'h11C, 32'h3000); wr(12'h120, 32'h020);
        wr(12'h124, 32'h4000); wr(12'h128, 32'h40FF); wr(12'h12C, 32'hFFFF_FFFF);
        wr(12'h004, 32'hB);
        rdreg(12'h12C, rd); chk(rd, 32'h777, "R4 attr readback");
        rdreg(12'h10C, rd); chk(rd, 32'h1800, "R12 window1 lower");

        for (int i = 0; i < NV; i++) begin
            issue(0, VEC[i][36:5], 5'd1, VEC[i][4:3], VEC[i][2:1]);
            chk(32'(resp_grant[0]), 32'(VEC[i][0]), $sformatf("R1/R2/R3 table[%0d]", i));
            wr(12'h204, 32'h1);
        end

        // R6 response timing
        issue(0, 32'h9000, 5'd0, 2'd0, 2'd0);
        chk(32'(resp_valid[0]), 1, "R6 resp after request");
        @(negedge clk);
        chk(32'(resp_valid[0]), 0, "R6 resp drops");

        // R5 disabled path 2
        issue(2, 32'h1500, 5'd4, 2'd3, 2'd0);
        chk(32'(resp_grant[2]), 1, "R5 grant on off path");
        rdreg(12'h220, rd); chk(rd, 0, "R5 no flag on off path");

        // R7 R8 R10 capture
        wr(12'h008, 32'h1);
        issue(0, 32'h1500, 5'd7, 2'd3, 2'd0);
        chk(32'(irq[0]), 1, "R10 irq raised");
        rdreg(12'h200, rd); chk(rd, 1, "R7 flag set");
        rdreg(12'h208, rd); chk(rd, 32'h001F_0001, "R8 info0");
        rdreg(12'h20C, rd); chk(rd, 32'h1500, "R8 info1");
        issue(0, 32'h2000, 5'd9, 2'd1, 2'd1);
        rdreg(12'h208, rd); chk(rd, 32'h001F_0001, "R7 info0 kept");
        rdreg(12'h20C, rd); chk(rd, 32'h1500, "R7 info1 kept");

        // R9 write with bit0 clear ignored, then clear
        wr(12'h204, 32'h2);
        rdreg(12'h200, rd); chk(rd, 1, "R9 bit0 clear ignored");
        wr(12'h204, 32'h1);
        rdreg(12'h200, rd); chk(rd, 0, "R9 cleared");
        chk(32'(irq[0]), 0, "R10 irq cleared");

        // R9 clear meets violation, R8 overlap map
        issue(0, 32'h1500, 5'd7, 2'd3, 2'd0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 12'h204; cfg_wdata = 32'h1;
        drive(0, 32'h1800, 5'd3, 2'd2, 2'd1);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = '0;
        rdreg(12'h200, rd); chk(rd, 1, "R9 set wins");
        rdreg(12'h208, rd); chk(rd, 32'h000E_0003, "R8 overlap map");

        // R10 irq masked
        wr(12'h008, 32'h0);
        #1 chk(32'(irq[0]), 0, "R10 irq masked");
        wr(12'h204, 32'h1);

        // paths independent
        issue(1, 32'h1500, 5'd2, 2'd3, 2'd0);
        rdreg(12'h210, rd); chk(rd, 1, "R7 path1 flag");
        rdreg(12'h200, rd); chk(rd, 0, "R7 path0 untouched");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule